// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Real-Time Hold-Off

This block paces auto-refresh requests for a DRAM controller. A free-running timer marks one owed refresh per refresh period. At the default 132 MHz clock that is 1030 cycles, about 7.8 µs. Owed refreshes are stored in a small saturating counter. They are handed to the controller one at a time over a request/acknowledge handshake.

A flash-emulation front end raises `inhibit_i` for as long as a latency-critical serial read is running. While it is high, no new refresh is offered. Refreshes that fall due during that time are kept and then issued back to back once the hold-off ends. The long-run average rate is therefore kept. A refresh the controller has already accepted runs to completion, because the block never withdraws an accepted request. If more refreshes fall due than the counter can hold, a sticky error flag is raised.

Top module: `refresh_scheduler`

## Requirements
- R1: While reset is asserted and on its release, `ref_req_o` and `ovf_err_o` are low and no refresh is owed.
- R2: One refresh becomes owed every `INTERVAL` clocks. The first one falls due on the `INTERVAL`-th rising edge after reset release, and `ref_req_o` rises right after that edge.
- R3: While `inhibit_i` is high, `ref_req_o` is low, so no handshake can occur.
- R4: Once raised, `ref_req_o` stays high until a cycle with `ref_ack_i` high, unless `inhibit_i` rises. `ref_ack_i` may be high without a request and then has no effect.
- R5: Every refresh that falls due while `inhibit_i` is high is issued after it falls, with no refresh lost.
- R6: After a handshake, `ref_req_o` stays low for at least one cycle, and then for as long as `ctrl_busy_i` is high. No request is offered while `ctrl_busy_i` is high.
- R7: An inhibit pulse that rises after a handshake does not cancel or repeat the refresh that was accepted.
- R8: At most `OWED_MAX` refreshes are owed. If a refresh falls due when the count is full and none is being accepted in that cycle, the extra refresh is dropped and `ovf_err_o` goes high and stays high until reset.
- R9: When a refresh falls due in the same cycle as a handshake, the owed count is unchanged, so neither event is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| inhibit_i | input | 1 | High while a time-critical read is active; blocks new refreshes |
| ctrl_busy_i | input | 1 | High while the controller is executing a command |
| ref_ack_i | input | 1 | Controller accepts the offered refresh (ready) |
| ref_req_o | output | 1 | A refresh is offered (valid) |
| ovf_err_o | output | 1 | Sticky flag: an owed refresh was dropped |

## Verification
Two events can land in the same cycle: the timer marking a new owed refresh, and the controller accepting the previous one. The bench holds `ref_ack_i` low so that the first request waits. It then enables acceptance so that the handshake falls exactly on the edge of the second period. Afterwards it checks that exactly two refreshes are issued before the third period begins. A lost increment or a lost decrement would change that count.

// File: rtl/rfs_pkg.sv
package rfs_pkg;
  typedef enum logic [1:0] {
    ISS_IDLE  = 2'd0,
    ISS_HOLD  = 2'd1,
    ISS_DRAIN = 2'd2
  } iss_state_t;
endpackage

// File: rtl/rfs_interval_timer.sv
module rfs_interval_timer #(
  parameter int INTERVAL = 1030
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/rfs_owed_counter.sv
module rfs_owed_counter #(
  parameter int OWED_MAX = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic due_i,
  input  logic take_i,
  output logic pending_o,
  output logic err_o
);
  localparam int OW = $clog2(OWED_MAX + 1);
  localparam logic [OW-1:0] FULL = OW'(OWED_MAX);

  logic [OW-1:0] owed_q;

  assign pending_o = (owed_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      owed_q <= '0;
      err_o  <= 1'b0;
    end else begin
      unique case ({due_i, take_i})
        2'b10: begin
          if (owed_q == FULL) err_o  <= 1'b1;
          else                owed_q <= owed_q + 1'b1;
        end
        2'b01:   owed_q <= owed_q - 1'b1;
        default: owed_q <= owed_q;
      endcase
    end
  end
endmodule

// File: rtl/rfs_issue_fsm.sv
module rfs_issue_fsm
  import rfs_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pending_i,
  input  logic inhibit_i,
  input  logic busy_i,
  input  logic ack_i,
  output logic req_o,
  output logic take_o
);
  iss_state_t state_q, state_d;

  assign req_o  = (state_q == ISS_IDLE) && pending_i && !inhibit_i && !busy_i;
  assign take_o = req_o && ack_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ISS_IDLE:  if (take_o) state_d = ISS_HOLD;
      ISS_HOLD:  state_d = ISS_DRAIN;
      ISS_DRAIN: if (!busy_i) state_d = ISS_IDLE;
      default:   state_d = ISS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ISS_IDLE;
    else         state_q <= state_d;
  end
endmodule

// File: rtl/refresh_scheduler.sv
module refresh_scheduler #(
  parameter int INTERVAL = 1030,
  parameter int OWED_MAX = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inhibit_i,
  input  logic ctrl_busy_i,
  input  logic ref_ack_i,
  output logic ref_req_o,
  output logic ovf_err_o
);
  logic due, take, pending;

  rfs_interval_timer #(.INTERVAL(INTERVAL)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (due)
  );

  rfs_owed_counter #(.OWED_MAX(OWED_MAX)) u_owed (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .due_i     (due),
    .take_i    (take),
    .pending_o (pending),
    .err_o     (ovf_err_o)
  );

  rfs_issue_fsm u_issue (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pending_i (pending),
    .inhibit_i (inhibit_i),
    .busy_i    (ctrl_busy_i),
    .ack_i     (ref_ack_i),
    .req_o     (ref_req_o),
    .take_o    (take)
  );
endmodule

// File: rtl/rfs_checker.sv
module rfs_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic inhibit_i,
  input logic ctrl_busy_i,
  input logic ref_ack_i,
  input logic ref_req_o,
  input logic ovf_err_o
);
  p_quiet_inhibit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inhibit_i |-> !ref_req_o);

  p_hold_valid_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_req_o && !ref_ack_i) ##1 !inhibit_i |-> ref_req_o);

  p_gap_after_ack_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_req_o && ref_ack_i) |=> !ref_req_o);

  p_quiet_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_busy_i |-> !ref_req_o);

  p_err_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_err_o |=> ovf_err_o);
endmodule

bind refresh_scheduler rfs_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .inhibit_i   (inhibit_i),
  .ctrl_busy_i (ctrl_busy_i),
  .ref_ack_i   (ref_ack_i),
  .ref_req_o   (ref_req_o),
  .ovf_err_o   (ovf_err_o)
);

// File: tb/sim_refresh_scheduler.sv
module sim_refresh_scheduler;
  localparam int N   = 64;
  localparam int MAX = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inhibit = 1'b0;
  logic busy = 1'b0;
  logic ack = 1'b0;
  logic ack_en = 1'b0;
  logic req, err;

  int cyc = 0;
  int n_checks = 0;
  int n_fail = 0;
  int hs_cnt = 0;
  int bcnt = 0;
  int exp_q[$];

  always #4 clk = ~clk;

  refresh_scheduler #(.INTERVAL(N), .OWED_MAX(MAX)) u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .inhibit_i   (inhibit),
    .ctrl_busy_i (busy),
    .ref_ack_i   (ack),
    .ref_req_o   (req),
    .ovf_err_o   (err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  task automatic upto(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic expect_refreshes(input int n);
    for (int i = 0; i < n; i++) exp_q.push_back(i);
  endtask

  // Controller model and scoreboard monitor
  always @(posedge clk) begin
    if (rst_n) begin
      cyc <= cyc + 1;
      if (req && ack) begin
        chk("R3 handshake with inhibit low", int'(inhibit), 0);
        chk("R6 handshake with busy low", int'(busy), 0);
        if (exp_q.size() == 0) chk("R8 unexpected refresh", 1, 0);
        else void'(exp_q.pop_front());
        hs_cnt++;
        busy <= 1'b1;
        bcnt <= 7;
        ack  <= 1'b0;
      end else if (bcnt > 0) begin
        bcnt <= bcnt - 1;
        if (bcnt == 1) busy <= 1'b0;
      end else begin
        ack <= ack_en;
      end
    end
  end

  initial begin
    #150000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 req in reset", int'(req), 0);
    chk("R1 err in reset", int'(err), 0);
    rst_n = 1'b1;
    chk("R1 req after release", int'(req), 0);

    upto(N - 1);
    chk("R2 no request before period", int'(req), 0);
    upto(N);
    chk("R2 request after first period", int'(req), 1);
    upto(80);
    chk("R4 request held without ack", int'(req), 1);
    upto(100);
    chk("R4 request still held", int'(req), 1);

    // R9: handshake lands on the edge of the second period
    expect_refreshes(2);
    upto(2 * N - 2);
    ack_en = 1'b1;
    upto(180);
    chk("R9 two refreshes around coincident edge", hs_cnt, 2);

    // R3 / R5 / R6 / R7: hold-off across three periods
    upto(190);
    inhibit = 1'b1;
    upto(200);
    chk("R3 no request under inhibit", int'(req), 0);
    upto(300);
    chk("R3 still no request under inhibit", int'(req), 0);
    chk("R5 nothing issued during inhibit", hs_cnt, 2);
    expect_refreshes(3);
    upto(330);
    inhibit = 1'b0;
    upto(331);
    chk("R6 first owed refresh accepted", hs_cnt, 3);
    chk("R6 no request right after handshake", int'(req), 0);
    upto(332);
    inhibit = 1'b1;
    upto(335);
    inhibit = 1'b0;
    upto(383);
    chk("R5 R7 all owed refreshes issued once", hs_cnt, 5);

    // R8: overflow
    ack_en = 1'b0;
    upto(4 * N + 5 * N - 4 * N + 5 * N - 2 * N + 1 * N - 1 * N + 600 - 9 * N);
    upto(600);
    chk("R8 no error at full count", int'(err), 0);
    chk("R4 request held at full count", int'(req), 1);
    upto(641);
    chk("R8 error after overflow", int'(err), 1);
    expect_refreshes(MAX);
    ack_en = 1'b1;
    upto(700);
    chk("R8 saturated count issued", hs_cnt, 9);
    chk("R8 error sticky", int'(err), 1);
    upto(703);
    chk("R5 scoreboard drained", exp_q.size(), 0);

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule